// File: doc/BRIEF.md
# Pin-Selectable Decade/Binary Clock Divider

This block divides a fast input clock by 10, 20, 40 or 80 and produces one square-wave output clock. A divide-by-five counter feeds a toggle flop, which gives a divide-by-ten point. Three further toggle stages follow it and give the divide-by-20, divide-by-40 and divide-by-80 points. A tap multiplexer picks one of these four points. The block is single modulus: it has no swallow or mode-change input.

The ratio is set by three static control bits, and each of the three counts the same. The block counts how many of them are high. Each high bit removes one divide-by-two stage from the path. So the ratio depends only on that count, not on which bits are high. A control that is not driven must be tied or pulled low at integration, and a low bit reads as deasserted, so a floating control selects the slower ratio.

The controls pass through a two-flop synchronizer. A new ratio is taken only when the current output period ends, at the falling edge of the output. The whole stage chain then restarts from zero, so a ratio change never produces a runt pulse.

Top module: `clk_ratio_div`

## Requirements
- R1: When no control bit is high (ratio_ctl = 3'b000), the output period is 80 input cycles.
- R2: When exactly one control bit is high (3'b001, 3'b010 or 3'b100), the output period is 40 input cycles, whichever bit it is.
- R3: When exactly two control bits are high (3'b011, 3'b101 or 3'b110), the output period is 20 input cycles.
- R4: When all three control bits are high (3'b111), the output period is 10 input cycles.
- R5: At every ratio the output is high for exactly half the period and low for exactly half the period.
- R6: While arst_n is low, the output is low. Asserting arst_n forces the output low at once, without waiting for a clock edge.
- R7: After arst_n is released, count the input clock edges from the first one. The output first rises at edge 2 + N/2, where N is the ratio selected by the controls held steady through reset. The 2 is the synchronizer depth.
- R8: A change of the control count takes effect only at a falling edge of the output. No high or low phase around a change is shorter than half the smaller of the old and new periods. At most three output periods after the change, the new period is in force.
- R9: A change of the controls that keeps the number of high bits the same has no effect on the output waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Input clock to be divided |
| arst_n | input | 1 | Asynchronous reset, active low |
| ratio_ctl | input | 3 | Ratio controls, each high bit removes one divide-by-two stage; tie low when unused |
| div_clk | output | 1 | Divided clock, registered |

## Verification
All eight control combinations are applied from reset. For each one the bench measures the delay to the first rising edge, then the high and low phase lengths over several periods. This separates the four ratios and shows that bits with the same count are treated alike. Mid-period changes between widely different counts are then made at several offsets inside a phase. These runs separate a clean change at the period boundary from one that truncates a phase. Swaps between different bits with the same count check that a change with no effect really leaves the waveform untouched.

// File: rtl/div_pkg.sv
package div_pkg;

    // default pre-divider modulus and number of binary stages
    localparam int unsigned DEF_PRE_DIV    = 5;
    localparam int unsigned DEF_N_STAGES   = 3;
    localparam int unsigned DEF_SYNC_DEPTH = 2;

    // number of high bits in a control word
    function automatic int unsigned high_count(input logic [31:0] v, input int unsigned w);
        int unsigned c;
        c = 0;
        for (int i = 0; i < 32; i++) begin
            if (i < w && v[i]) c++;
        end
        return c;
    endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int unsigned W     = 3,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] ctl_i,
    output logic [W-1:0] ctl_o,
    output logic         ready_o
);
    localparam int unsigned WARM_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
        logic [WARM_W-1:0]       warm;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d        = q;
        d.stg[0] = ctl_i;
        for (int i = 1; i < int'(DEPTH); i++) begin
            d.stg[i] = q.stg[i-1];
        end
        if (q.warm != WARM_W'(DEPTH)) d.warm = q.warm + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= d;
    end

    assign ctl_o   = q.stg[DEPTH-1];
    assign ready_o = (q.warm == WARM_W'(DEPTH));

    // R7
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
        ready_o |=> ready_o);

endmodule

// File: rtl/ratio_decode.sv
module ratio_decode #(
    parameter int unsigned N_STAGES = 3,
    localparam int unsigned TAP_W   = $clog2(N_STAGES + 1)
) (
    input  logic [N_STAGES-1:0] ctl_i,
    output logic [TAP_W-1:0]    tap_o
);
    import div_pkg::*;

    // each high control removes one binary stage from the path
    always_comb begin
        tap_o = TAP_W'(N_STAGES - high_count(32'(ctl_i), N_STAGES));
    end

endmodule

// File: rtl/div_chain.sv
module div_chain #(
    parameter int unsigned PRE_DIV  = 5,
    parameter int unsigned N_STAGES = 3,
    localparam int unsigned TAP_W   = $clog2(N_STAGES + 1)
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             run_i,
    input  logic [TAP_W-1:0] tap_req_i,
    output logic             div_o
);
    localparam int unsigned PRE_W  = $clog2(PRE_DIV);
    localparam int unsigned N_TAPS = N_STAGES + 1;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [N_TAPS-1:0] tog;
        logic [TAP_W-1:0]  sel;
        logic              started;
        logic              out;
    } chain_t;

    chain_t            q, d;
    logic [N_TAPS-1:0] live_mask;
    logic              wrap;
    logic              period_end;
    logic              carry;

    always_comb begin
        d = q;
        for (int i = 0; i < int'(N_TAPS); i++) begin
            live_mask[i] = (i <= int'(q.sel));
        end
        wrap       = (q.pre == PRE_W'(PRE_DIV - 1));
        period_end = wrap && ((q.tog | ~live_mask) == '1);
        carry      = 1'b0;

        if (!run_i) begin
            d     = '0;
            d.sel = tap_req_i;
        end else begin
            if (!q.started) begin
                d.started = 1'b1;
                d.sel     = tap_req_i;
            end
            d.pre = wrap ? '0 : q.pre + 1'b1;
            carry = wrap;
            for (int i = 0; i < int'(N_TAPS); i++) begin
                if (carry) d.tog[i] = ~q.tog[i];
                carry = carry & q.tog[i];
            end
            // selected tap falls: restart the chain, take a new ratio
            if (period_end) begin
                d.tog = '0;
                if (q.started) d.sel = tap_req_i;
            end
        end
        d.out = d.tog[d.sel];
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= d;
    end

    assign div_o = q.out;

    // R5
    pre_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
        int'(q.pre) < int'(PRE_DIV));

    // R5
    rise_aligned_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(q.out) |-> (q.pre == '0));

    // R1
    unused_taps_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
        q.started |-> ((q.tog & ~live_mask) == '0));

    // R8
    sel_on_boundary_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (q.sel != $past(q.sel)) |-> (!$past(q.started) || ($past(q.out) && !q.out)));

endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
    parameter int unsigned PRE_DIV    = div_pkg::DEF_PRE_DIV,
    parameter int unsigned N_STAGES   = div_pkg::DEF_N_STAGES,
    parameter int unsigned SYNC_DEPTH = div_pkg::DEF_SYNC_DEPTH
) (
    input  logic                fast_clk,
    input  logic                arst_n,
    input  logic [N_STAGES-1:0] ratio_ctl,
    output logic                div_clk
);
    localparam int unsigned TAP_W = $clog2(N_STAGES + 1);

    logic [N_STAGES-1:0] ctl_s;
    logic                ready;
    logic [TAP_W-1:0]    tap;

    ctl_sync #(.W(N_STAGES), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (fast_clk),
        .arst_n  (arst_n),
        .ctl_i   (ratio_ctl),
        .ctl_o   (ctl_s),
        .ready_o (ready)
    );

    ratio_decode #(.N_STAGES(N_STAGES)) u_dec (
        .ctl_i (ctl_s),
        .tap_o (tap)
    );

    div_chain #(.PRE_DIV(PRE_DIV), .N_STAGES(N_STAGES)) u_chain (
        .clk       (fast_clk),
        .arst_n    (arst_n),
        .run_i     (ready),
        .tap_req_i (tap),
        .div_o     (div_clk)
    );

endmodule

// File: tb/sim_clk_ratio_div.sv
`timescale 1ns/1ps
module sim_clk_ratio_div;

    logic       fast_clk = 1'b0;
    logic       arst_n   = 1'b0;
    logic [2:0] ratio_ctl = 3'b000;
    logic       div_clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    clk_ratio_div u0 (
        .fast_clk  (fast_clk),
        .arst_n    (arst_n),
        .ratio_ctl (ratio_ctl),
        .div_clk   (div_clk)
    );

    always #2.5 fast_clk = ~fast_clk;

    always @(posedge fast_clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic int exp_ratio(input logic [2:0] c);
        return 10 << (3 - $countones(c));
    endfunction

    function automatic string ratio_tag(input logic [2:0] c);
        case ($countones(c))
            0:       return "R1";
            1:       return "R2";
            2:       return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // count negedges until the output shows level v
    task automatic wait_for(input logic v, output int n);
        n = 0;
        while (div_clk !== v) begin
            @(negedge fast_clk);
            n++;
        end
    endtask

    task automatic start(input logic [2:0] c);
        @(negedge fast_clk);
        arst_n    = 1'b0;
        ratio_ctl = c;
        repeat (3) @(negedge fast_clk);
        arst_n = 1'b1;
    endtask

    initial begin
        int n;
        int r;
        // all eight combinations from reset
        for (int c = 0; c < 8; c++) begin
            r = exp_ratio(3'(c));
            @(negedge fast_clk);
            arst_n    = 1'b0;
            ratio_ctl = 3'(c);
            repeat (3) @(negedge fast_clk);
            check(div_clk === 1'b0, "R6 low in reset", int'(div_clk), 0);
            arst_n = 1'b1;
            wait_for(1'b1, n);
            check(n == 2 + r / 2, "R7 first rise", n, 2 + r / 2);
            for (int p = 0; p < 2; p++) begin
                wait_for(1'b0, n);
                check(n == r / 2, "R5 high time", n, r / 2);
                wait_for(1'b1, n);
                check(n == r / 2, ratio_tag(3'(c)), n, r / 2);
            end
            // output is high here: reset must clear it before any edge
            #1 arst_n = 1'b0;
            #0.5;
            check(div_clk === 1'b0, "R6 async clear", int'(div_clk), 0);
        end

        // ratio changes mid-period
        begin
            logic [2:0] from_l [6] = '{3'b000, 3'b111, 3'b001, 3'b011, 3'b110, 3'b000};
            logic [2:0] to_l   [6] = '{3'b111, 3'b000, 3'b011, 3'b001, 3'b000, 3'b101};
            for (int t = 0; t < 6; t++) begin
                for (int k = 0; k < 4; k++) begin
                    int ra;
                    int rb;
                    int mn;
                    int off;
                    logic v;
                    ra  = exp_ratio(from_l[t]);
                    rb  = exp_ratio(to_l[t]);
                    mn  = (ra < rb ? ra : rb) / 2;
                    off = (k == 0) ? 1 : (k == 1) ? ra / 4 : (k == 2) ? ra / 2 - 1 : ra / 2 + 3;
                    start(from_l[t]);
                    wait_for(1'b1, n);
                    repeat (off) @(negedge fast_clk);
                    ratio_ctl = to_l[t];
                    v = div_clk;
                    wait_for(~v, n);
                    v = ~v;
                    for (int p = 0; p < 6; p++) begin
                        wait_for(~v, n);
                        check(n >= mn, "R8 no short phase", n, mn);
                        v = ~v;
                    end
                    wait_for(1'b1, n);
                    wait_for(1'b0, n);
                    check(n == rb / 2, "R8 new high", n, rb / 2);
                    wait_for(1'b1, n);
                    check(n == rb / 2, "R8 new low", n, rb / 2);
                end
            end
        end

        // same count, different bits: waveform unchanged
        begin
            logic [2:0] a_l [2] = '{3'b001, 3'b011};
            logic [2:0] b_l [2] = '{3'b100, 3'b110};
            for (int t = 0; t < 2; t++) begin
                logic v;
                r = exp_ratio(a_l[t]);
                start(a_l[t]);
                wait_for(1'b1, n);
                wait_for(1'b0, n);
                repeat (3) @(negedge fast_clk);
                ratio_ctl = b_l[t];
                wait_for(1'b1, n);
                check(n == r / 2 - 3, "R9 low phase kept", n, r / 2 - 3);
                v = 1'b1;
                for (int p = 0; p < 4; p++) begin
                    wait_for(~v, n);
                    check(n == r / 2, "R9 phase kept", n, r / 2);
                    v = ~v;
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule